// File: doc/BRIEF.md
# Debug-Mode Entry Controller

This block decides when a processor core must stop and enter its debug state. It takes in every kind of halt request: a debug opcode loaded into the JTAG instruction register, a falling edge on the external active-low debug-event pin, a software debug instruction, breakpoint and trace triggers, and a resume command from the debugger. It gates each request by its own enable fields. It then chooses the cycle in which the halt takes effect, using the core's run condition: running, in hardware reset, in stop/wait, or stalled in memory wait states.

The block reports a 2-bit run status and raises a halt request to the core while it is in debug. While it is in a debug session caused by the JTAG port or by the pin, it pulls the event pin low through an open-drain drive. Every accepted request feeds one pending flag. That flag survives core reset as long as the JTAG port is not itself in reset, so a request made during reset halts the core as soon as reset ends. A resume with single-execute selected runs one instruction and then returns to debug by itself.

The block has no data stream. All pins are plain level or single-cycle strobe controls, with no valid/ready handshake and no back-pressure.

Top module: `dbg_entry_ctrl`

## Requirements
- R1: `status` is 2'b11 in debug. Outside debug it is 2'b01 when `stop_wait` is high, otherwise 2'b10 when `wait_state` is high, otherwise 2'b00. Stop/wait takes priority over wait states.
- R2: A JTAG request is a cycle with `jtag_ir_upd` high and `jtag_ir_op` equal to 4'b0111. While running, the halt waits until an `instr_done` cycle, and `status` is 2'b11 from the following edge. Any other opcode is ignored.
- R3: The event pin passes through a two-flop synchroniser. A high-to-low transition acts like a JTAG request, and with `instr_done` held high `status` reaches 2'b11 after the third clock edge. A pin that stays low causes no further request.
- R4: A request made while `core_rst_n` is low and `trst_n` is high is kept. The first edge after `core_rst_n` rises enters debug without any `instr_done`. A request made while `trst_n` is low is lost.
- R5: A pending request while `stop_wait` is high wakes the core and enters debug at the next edge, without needing `instr_done`.
- R6: A request made during wait states stays pending for any number of stalled cycles, and takes effect at the `instr_done` that ends the stall.
- R7: `sw_dbg_instr` requests a halt only when `cfg_pwd` is 0 and `cfg_em` is 2'b00. Otherwise it is ignored.
- R8: `bkpt_hit` requests a halt only when all of the following hold: `cfg_em` is 2'b00, `cfg_tcnt` is zero, `cfg_be` is not 2'b00, and `bkpt_arm_first` is low.
- R9: With `trace_mode` high, `cfg_em` 2'b00 and `cfg_tcnt` zero, the next `instr_done` enters debug. Under any other enable setting, trace has no effect.
- R10: In debug, `dbg_go` with `cfg_ex` = 0 leaves debug for one instruction and shows a non-debug status. The `instr_done` of that instruction re-enters debug at the next edge. With `cfg_ex` = 1, `dbg_go` resumes normal running.
- R11: `pin_drv_low` is high only in a debug session entered on a JTAG or pin request while `cfg_pin_oe` is 1. It is low for sessions entered on internal causes, and it is released on leaving debug.
- R12: All simultaneous requests merge into one pending flag, which is cleared on entry to debug. Requests that arrive while in debug are discarded, so a resume does not halt again.
- R13: `halt_req` is high exactly while `status` is 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| trst_n | input | 1 | JTAG port reset, active low; clears the pending flag and the pin synchroniser |
| core_rst_n | input | 1 | Core hardware reset, active low; clears the run-state machine |
| jtag_ir_upd | input | 1 | Strobe: Update-IR passed |
| jtag_ir_op | input | 4 | Instruction register contents |
| evt_pin_in | input | 1 | Debug-event pin level, active low |
| sw_dbg_instr | input | 1 | Strobe: software debug instruction executed |
| bkpt_hit | input | 1 | Strobe: breakpoint address match |
| bkpt_arm_first | input | 1 | The current match is the arming step of a sequential pair |
| trace_mode | input | 1 | Trace mode selected |
| stop_wait | input | 1 | Core is in stop or wait |
| wait_state | input | 1 | Core is stalled in external wait states |
| instr_done | input | 1 | Strobe: instruction completes this cycle |
| dbg_go | input | 1 | Strobe: debugger issues an instruction / resume |
| cfg_em | input | 2 | Event-mode field; 2'b00 allows halts |
| cfg_pwd | input | 1 | Power-down disable of the software halt |
| cfg_be | input | 2 | Breakpoint enable; 2'b00 disables breakpoints |
| cfg_tcnt | input | CNT_W (8) | Trigger counter; halts need zero |
| cfg_ex | input | 1 | 0 = run one instruction and return to debug; 1 = exit debug |
| cfg_pin_oe | input | 1 | Allows driving the event pin |
| status | output | 2 | Run status code |
| halt_req | output | 1 | Halt request to the core |
| pin_drv_low | output | 1 | Open-drain pull-down of the event pin |

## Verification
Each halt is visible on `status` one edge after the qualifying cycle. For a JTAG, software, breakpoint or trace request, the qualifying cycle is the `instr_done` cycle. For a stop/wait wake it is the request cycle. For a request held across reset it is the first edge after reset ends. The pin path adds its two synchroniser stages, so its result is due at the third edge. The bench drives inputs on falling edges and reads the outputs at the next falling edge, after the number of edges listed above. It also re-reads the outputs after extra idle cycles with `instr_done` held high, which shows that an ignored or discarded request left nothing pending.

// File: rtl/dbg_entry_pkg.sv
package dbg_entry_pkg;

  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_DBG  = 2'd1,
    ST_STEP = 2'd2
  } dbg_state_e;

  localparam logic [1:0] STS_NORMAL = 2'b00;
  localparam logic [1:0] STS_SLEEP  = 2'b01;
  localparam logic [1:0] STS_STALL  = 2'b10;
  localparam logic [1:0] STS_DEBUG  = 2'b11;

  function automatic logic [1:0] run_status(input logic sleep, input logic stall);
    if (sleep)      return STS_SLEEP;
    else if (stall) return STS_STALL;
    else            return STS_NORMAL;
  endfunction

endpackage

// File: rtl/dbg_pin_sync.sv
module dbg_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_in,
  output logic fall
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= 1'b1;
          else        chain_q[g] <= pin_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= 1'b1;
          else        chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= chain_q[LAST];
  end

  // high-to-low transition of the synchronised level
  assign fall = prev_q & ~chain_q[LAST];

endmodule

// File: rtl/dbg_req_gate.sv
module dbg_req_gate #(
  parameter int              IR_W   = 4,
  parameter int              CNT_W  = 8,
  parameter logic [IR_W-1:0] DBG_OP = 4'b0111
) (
  input  logic             jtag_ir_upd,
  input  logic [IR_W-1:0]  jtag_ir_op,
  input  logic             pin_fall,
  input  logic             sw_dbg_instr,
  input  logic             bkpt_hit,
  input  logic             bkpt_arm_first,
  input  logic             trace_mode,
  input  logic             instr_done,
  input  logic [1:0]       cfg_em,
  input  logic             cfg_pwd,
  input  logic [1:0]       cfg_be,
  input  logic [CNT_W-1:0] cfg_tcnt,
  output logic             ext_req,
  output logic             int_req
);
  logic em_open, cnt_zero, sw_ok, bk_ok, tr_ok, jtag_ok;

  always_comb begin
    em_open  = (cfg_em == 2'b00);
    cnt_zero = (cfg_tcnt == '0);
    jtag_ok  = jtag_ir_upd & (jtag_ir_op == DBG_OP);
    sw_ok    = sw_dbg_instr & ~cfg_pwd & em_open;
    bk_ok    = bkpt_hit & em_open & cnt_zero & (cfg_be != 2'b00) & ~bkpt_arm_first;
    tr_ok    = trace_mode & em_open & cnt_zero & instr_done;
    ext_req  = jtag_ok | pin_fall;
    int_req  = sw_ok | bk_ok | tr_ok;
  end

endmodule

// File: rtl/dbg_mode_fsm.sv
module dbg_mode_fsm
  import dbg_entry_pkg::*;
(
  input  logic       clk,
  input  logic       trst_n,
  input  logic       core_rst_n,
  input  logic       ext_req,
  input  logic       int_req,
  input  logic       instr_done,
  input  logic       stop_wait,
  input  logic       wait_state,
  input  logic       dbg_go,
  input  logic       cfg_ex,
  input  logic       cfg_pin_oe,
  output logic [1:0] status,
  output logic       halt_req,
  output logic       pin_drv_low,
  output logic       in_step
);
  dbg_state_e state_q, state_d;
  logic pend_q, pend_ext_q, drv_q, started_q;
  logic open_in, acc_ext, acc_int, pend_now, ext_now;
  logic enter_run, enter_step, enter, leave;

  always_comb begin
    open_in    = (state_q != ST_DBG);
    acc_ext    = ext_req & open_in;
    acc_int    = int_req & open_in & core_rst_n;
    pend_now   = pend_q | acc_ext | acc_int;
    ext_now    = pend_ext_q | acc_ext;
    enter_run  = core_rst_n & (state_q == ST_RUN) & pend_now &
                 (instr_done | stop_wait | ~started_q);
    enter_step = core_rst_n & (state_q == ST_STEP) & instr_done;
    enter      = enter_run | enter_step;
    leave      = (state_q == ST_DBG) & dbg_go;

    state_d = state_q;
    unique case (state_q)
      ST_RUN:  if (enter_run)  state_d = ST_DBG;
      ST_DBG:  if (dbg_go)     state_d = cfg_ex ? ST_RUN : ST_STEP;
      ST_STEP: if (enter_step) state_d = ST_DBG;
      default:                 state_d = ST_RUN;
    endcase
  end

  // pending flag lives in the JTAG reset domain so it survives core reset
  always_ff @(posedge clk or negedge trst_n) begin
    if (!trst_n) begin
      pend_q     <= 1'b0;
      pend_ext_q <= 1'b0;
    end else if (enter) begin
      pend_q     <= 1'b0;
      pend_ext_q <= 1'b0;
    end else begin
      pend_q     <= pend_now;
      pend_ext_q <= ext_now;
    end
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      state_q   <= ST_RUN;
      started_q <= 1'b0;
      drv_q     <= 1'b0;
    end else begin
      state_q   <= state_d;
      started_q <= 1'b1;
      if (enter)      drv_q <= ext_now;
      else if (leave) drv_q <= 1'b0;
    end
  end

  always_comb begin
    status      = (state_q == ST_DBG) ? STS_DEBUG : run_status(stop_wait, wait_state);
    halt_req    = (state_q == ST_DBG);
    pin_drv_low = drv_q & cfg_pin_oe & (state_q == ST_DBG);
    in_step     = (state_q == ST_STEP);
  end

endmodule

// File: rtl/dbg_entry_ctrl.sv
module dbg_entry_ctrl #(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             trst_n,
  input  logic             core_rst_n,
  input  logic             jtag_ir_upd,
  input  logic [3:0]       jtag_ir_op,
  input  logic             evt_pin_in,
  input  logic             sw_dbg_instr,
  input  logic             bkpt_hit,
  input  logic             bkpt_arm_first,
  input  logic             trace_mode,
  input  logic             stop_wait,
  input  logic             wait_state,
  input  logic             instr_done,
  input  logic             dbg_go,
  input  logic [1:0]       cfg_em,
  input  logic             cfg_pwd,
  input  logic [1:0]       cfg_be,
  input  logic [CNT_W-1:0] cfg_tcnt,
  input  logic             cfg_ex,
  input  logic             cfg_pin_oe,
  output logic [1:0]       status,
  output logic             halt_req,
  output logic             pin_drv_low
);
  localparam int IR_W = 4;

  logic pin_fall, ext_req, int_req, in_step;

  dbg_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(trst_n), .pin_in(evt_pin_in), .fall(pin_fall)
  );

  dbg_req_gate #(.IR_W(IR_W), .CNT_W(CNT_W), .DBG_OP(4'b0111)) u_gate (
    .jtag_ir_upd(jtag_ir_upd), .jtag_ir_op(jtag_ir_op), .pin_fall(pin_fall),
    .sw_dbg_instr(sw_dbg_instr), .bkpt_hit(bkpt_hit),
    .bkpt_arm_first(bkpt_arm_first), .trace_mode(trace_mode),
    .instr_done(instr_done), .cfg_em(cfg_em), .cfg_pwd(cfg_pwd),
    .cfg_be(cfg_be), .cfg_tcnt(cfg_tcnt), .ext_req(ext_req), .int_req(int_req)
  );

  dbg_mode_fsm u_fsm (
    .clk(clk), .trst_n(trst_n), .core_rst_n(core_rst_n),
    .ext_req(ext_req), .int_req(int_req), .instr_done(instr_done),
    .stop_wait(stop_wait), .wait_state(wait_state), .dbg_go(dbg_go),
    .cfg_ex(cfg_ex), .cfg_pin_oe(cfg_pin_oe), .status(status),
    .halt_req(halt_req), .pin_drv_low(pin_drv_low), .in_step(in_step)
  );

endmodule

// File: rtl/dbg_entry_chk.sv
module dbg_entry_chk (
  input logic       clk,
  input logic       trst_n,
  input logic       core_rst_n,
  input logic       instr_done,
  input logic       stop_wait,
  input logic       dbg_go,
  input logic       cfg_ex,
  input logic       cfg_pin_oe,
  input logic [1:0] status,
  input logic       halt_req,
  input logic       pin_drv_low,
  input logic       in_step
);
  assert_halt_tracks_status_R13: assert property (@(posedge clk)
    disable iff (!core_rst_n || !trst_n) halt_req == (status == 2'b11));

  assert_sleep_code_R1: assert property (@(posedge clk)
    disable iff (!core_rst_n || !trst_n) (!halt_req && stop_wait) |-> status == 2'b01);

  assert_step_leaves_R10: assert property (@(posedge clk)
    disable iff (!core_rst_n || !trst_n)
    (halt_req && dbg_go && !cfg_ex) |=> (in_step && status != 2'b11));

  assert_step_returns_R10: assert property (@(posedge clk)
    disable iff (!core_rst_n || !trst_n) (in_step && instr_done) |=> halt_req);

  assert_debug_holds_R12: assert property (@(posedge clk)
    disable iff (!core_rst_n || !trst_n) (halt_req && !dbg_go) |=> halt_req);

  assert_pin_drive_scope_R11: assert property (@(posedge clk)
    disable iff (!core_rst_n || !trst_n) pin_drv_low |-> (halt_req && cfg_pin_oe));

endmodule

bind dbg_entry_ctrl dbg_entry_chk u_chk (
  .clk(clk), .trst_n(trst_n), .core_rst_n(core_rst_n),
  .instr_done(instr_done), .stop_wait(stop_wait), .dbg_go(dbg_go),
  .cfg_ex(cfg_ex), .cfg_pin_oe(cfg_pin_oe), .status(status),
  .halt_req(halt_req), .pin_drv_low(pin_drv_low), .in_step(in_step)
);

// File: tb/test_dbg_entry_ctrl.sv
module test_dbg_entry_ctrl;
  localparam int CNT_W = 8;

  logic clk = 1'b0;
  logic trst_n = 1'b0, core_rst_n = 1'b0;
  logic jtag_ir_upd = 1'b0;
  logic [3:0] jtag_ir_op = 4'd0;
  logic evt_pin_in = 1'b1;
  logic sw_dbg_instr = 1'b0, bkpt_hit = 1'b0, bkpt_arm_first = 1'b0, trace_mode = 1'b0;
  logic stop_wait = 1'b0, wait_state = 1'b0, instr_done = 1'b0, dbg_go = 1'b0;
  logic [1:0] cfg_em = 2'b00, cfg_be = 2'b00;
  logic cfg_pwd = 1'b0, cfg_ex = 1'b1, cfg_pin_oe = 1'b1;
  logic [CNT_W-1:0] cfg_tcnt = '0;
  logic [1:0] status;
  logic halt_req, pin_drv_low;

  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  dbg_entry_ctrl #(.CNT_W(CNT_W), .SYNC_STAGES(2)) i_dbg_entry_ctrl (
    .clk(clk), .trst_n(trst_n), .core_rst_n(core_rst_n),
    .jtag_ir_upd(jtag_ir_upd), .jtag_ir_op(jtag_ir_op), .evt_pin_in(evt_pin_in),
    .sw_dbg_instr(sw_dbg_instr), .bkpt_hit(bkpt_hit), .bkpt_arm_first(bkpt_arm_first),
    .trace_mode(trace_mode), .stop_wait(stop_wait), .wait_state(wait_state),
    .instr_done(instr_done), .dbg_go(dbg_go), .cfg_em(cfg_em), .cfg_pwd(cfg_pwd),
    .cfg_be(cfg_be), .cfg_tcnt(cfg_tcnt), .cfg_ex(cfg_ex), .cfg_pin_oe(cfg_pin_oe),
    .status(status), .halt_req(halt_req), .pin_drv_low(pin_drv_low)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic jtag_pulse(input logic [3:0] op);
    jtag_ir_upd = 1'b1; jtag_ir_op = op; step();
    jtag_ir_upd = 1'b0; jtag_ir_op = 4'd0;
  endtask

  task automatic resume();
    if (halt_req) begin
      cfg_ex = 1'b1; dbg_go = 1'b1; step(); dbg_go = 1'b0;
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
    $finish;
  end

  initial begin
    repeat (2) step();
    trst_n = 1'b1; step();
    core_rst_n = 1'b1; step();
    chk("R1 reset status", status, 0);
    chk("R13 reset halt", halt_req, 0);
    chk("R11 reset drive", pin_drv_low, 0);

    // R1 status code mapping
    for (int s = 0; s < 4; s++) begin
      stop_wait = s[0]; wait_state = s[1]; #1;
      chk("R1 status map", status, s[0] ? 1 : (s[1] ? 2 : 0));
    end
    stop_wait = 0; wait_state = 0; step();

    // R2 halt waits for instruction completion
    jtag_pulse(4'b0111);
    chk("R2 no halt before done", status, 0);
    repeat (3) step();
    chk("R2 still pending", status, 0);
    instr_done = 1; step();
    chk("R2 halt at done", status, 3);
    chk("R13 halt high", halt_req, 1);
    chk("R11 ext drive", pin_drv_low, 1);
    resume();
    chk("R11 drive released", pin_drv_low, 0);
    chk("R13 halt low", halt_req, 0);
    for (int op = 0; op < 16; op++) begin
      if (op != 7) begin
        jtag_pulse(4'(op)); step();
        chk("R2 other opcode ignored", status, 0);
      end
    end

    // R3 pin falling edge, two sync stages
    evt_pin_in = 0; step(); step();
    chk("R3 not yet", status, 0);
    step();
    chk("R3 pin halt", status, 3);
    resume();
    repeat (4) step();
    chk("R3 held low no retrigger", status, 0);
    evt_pin_in = 1; repeat (3) step();
    chk("R3 release no trigger", status, 0);

    // R11 enable off
    cfg_pin_oe = 0; jtag_pulse(4'b0111);
    chk("R11 oe off halt", status, 3);
    chk("R11 oe off no drive", pin_drv_low, 0);
    resume(); cfg_pin_oe = 1;

    // R4 request held across core reset
    instr_done = 0; core_rst_n = 0; step();
    jtag_pulse(4'b0111); step();
    core_rst_n = 1; step();
    chk("R4 exit reset into debug", status, 3);
    resume();
    core_rst_n = 0; trst_n = 0; step();
    jtag_pulse(4'b0111);
    trst_n = 1; step(); core_rst_n = 1; repeat (3) step();
    chk("R4 lost under port reset", status, 0);

    // R5 wake from stop/wait
    stop_wait = 1; step();
    jtag_pulse(4'b0111);
    chk("R5 wake to debug", status, 3);
    stop_wait = 0; resume();

    // R6 wait-state stall
    wait_state = 1; jtag_pulse(4'b0111);
    repeat (10) step();
    chk("R6 stalled status", status, 2);
    instr_done = 1; step(); instr_done = 0;
    chk("R6 halt at end of stall", status, 3);
    wait_state = 0; resume();

    // R7 software instruction sweep
    instr_done = 1;
    for (int c = 0; c < 8; c++) begin
      cfg_pwd = c[2]; cfg_em = 2'(c & 3);
      sw_dbg_instr = 1; step(); sw_dbg_instr = 0;
      chk("R7 sw gate", status, (c == 0) ? 3 : 0);
      if (c == 0) chk("R11 internal no drive", pin_drv_low, 0);
      resume(); step();
      chk("R7 nothing pending", status, 0);
    end
    cfg_pwd = 0; cfg_em = 0;

    // R8 breakpoint gating sweep
    for (int c = 0; c < 64; c++) begin
      cfg_em = 2'(c & 3); cfg_be = 2'((c >> 2) & 3);
      cfg_tcnt = c[4] ? 8'd1 : 8'd0; bkpt_arm_first = c[5];
      bkpt_hit = 1; step(); bkpt_hit = 0;
      chk("R8 bkpt gate", status,
          ((c & 3) == 0 && ((c >> 2) & 3) != 0 && !c[4] && !c[5]) ? 3 : 0);
      resume(); step();
    end
    cfg_em = 0; cfg_be = 0; cfg_tcnt = 0; bkpt_arm_first = 0;

    // R9 trace
    instr_done = 0; trace_mode = 1; repeat (3) step();
    chk("R9 trace waits", status, 0);
    instr_done = 1; step();
    chk("R9 trace halt", status, 3);
    resume();
    trace_mode = 1; cfg_em = 2'b01; step(); step();
    chk("R9 trace gated", status, 0);
    trace_mode = 0; cfg_em = 0;

    // R10 single execute
    instr_done = 0; jtag_pulse(4'b0111); instr_done = 1; step(); instr_done = 0;
    cfg_ex = 0; dbg_go = 1; step(); dbg_go = 0;
    chk("R10 step status", status, 0);
    chk("R10 step halt low", halt_req, 0);
    step();
    chk("R10 step running", status, 0);
    instr_done = 1; step(); instr_done = 0;
    chk("R10 reentry", status, 3);
    cfg_ex = 1; dbg_go = 1; step(); dbg_go = 0;
    instr_done = 1; repeat (3) step();
    chk("R10 exit stays run", status, 0);

    // R12 requests in debug discarded; merged sources
    jtag_pulse(4'b0111);
    jtag_pulse(4'b0111); sw_dbg_instr = 1; step(); sw_dbg_instr = 0;
    chk("R12 still debug", status, 3);
    resume(); repeat (3) step();
    chk("R12 no rehalt", status, 0);
    jtag_ir_upd = 1; jtag_ir_op = 4'b0111; sw_dbg_instr = 1; bkpt_hit = 1; cfg_be = 2'b01;
    step();
    jtag_ir_upd = 0; sw_dbg_instr = 0; bkpt_hit = 0;
    chk("R12 merged halt", status, 3);
    resume(); repeat (3) step();
    chk("R12 single flag cleared", status, 0);

    summary();
    $finish;
  end
endmodule